// File: doc/BRIEF.md
# External Oscillator Failure Guard

The block watches an external high-speed oscillator while that oscillator is the source of the system clock. The oscillator may feed the clock mux directly or through the PLL. A toggle flop in the monitored domain is sampled through a synchronizer in the domain of an always-running internal reference oscillator. A counter in that domain measures how long it has been since the toggle last changed. If the external clock stops, the block latches a failure pending bit. That bit drives a non-maskable interrupt request and a level break signal to the advanced timer.

The block also holds the clock-control state that the recovery sequence has to change. On a failure it moves the system clock selection to the internal high-speed oscillator, clears its own monitoring enable and clears the external oscillator enable. When the system clock was coming from the PLL, it also clears the PLL enable. Software writes this state through a simple configuration strobe and acknowledges the failure with a clear strobe. A small set of per-source ready flags, each with its own interrupt enable and clear, produces an ordinary maskable interrupt request.

Top module: `xosc_fail_guard`

## Requirements
- R1: After reset, nmi_o, brk_o, xosc_en_o, pll_en_o, det_en_o, irq_o and rdy_flag_o are 0, and sel_o is 0 (internal oscillator).
- R2: A cycle with cfg_wr_i high loads det_en_o, xosc_en_o, pll_en_o and sel_o from the cfg inputs at that edge. The selection encoding is 0 = internal oscillator, 1 = external oscillator direct, 2 = PLL. A write of 3 is stored as 0.
- R3: Monitoring runs only when det_en_o is 1 and either sel_o is 1, or sel_o is 2 with pll_src_ext_i high. In any other state a stopped monitored clock never raises nmi_o and leaves sel_o and the enables unchanged.
- R4: While monitoring runs, a monitored clock that stops is reported on nmi_o between TIMEOUT and TIMEOUT+8 reference cycles after it stops (TIMEOUT = 32 by default). A running monitored clock is never reported.
- R5: The failure forces sel_o to 0 and clears det_en_o and xosc_en_o. This happens on the edge after detection, which is the same edge on which nmi_o rises. A configuration write on that edge loses.
- R6: pll_en_o is cleared on failure only when sel_o was 2. A failure with sel_o = 1 leaves pll_en_o unchanged.
- R7: nmi_o and brk_o are the same level. They stay high until a one-cycle fail_clr_i pulse clears them on the next edge. Clearing does not restore sel_o or any enable.
- R8: fail_clr_i that coincides with detection keeps the pending bit (nmi_o, brk_o) at 0, but the forced switch and the enable clears still happen.
- R9: Each rdy_flag_o[i] sets on a rising edge of rdy_i[i], seen after a two-stage synchronizer. It is cleared by rdy_clr_i[i], and the clear wins over a set. irq_o is the OR of rdy_flag_o & rdy_ie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Always-running internal reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | 1 | Monitored external oscillator clock |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_det_en_i | input | 1 | Monitoring enable value to write |
| cfg_xosc_en_i | input | 1 | External oscillator enable value to write |
| cfg_pll_en_i | input | 1 | PLL enable value to write |
| cfg_sel_i | input | 2 | System clock selection to write |
| pll_src_ext_i | input | 1 | PLL reference is the external oscillator |
| fail_clr_i | input | 1 | Failure pending clear strobe |
| rdy_i | input | N_SRC | Per-source stable indications |
| rdy_ie_i | input | N_SRC | Per-source ready interrupt enables |
| rdy_clr_i | input | N_SRC | Per-source ready flag clear strobes |
| sel_o | output | 2 | System clock mux selection |
| xosc_en_o | output | 1 | External oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| det_en_o | output | 1 | Failure monitoring enable |
| nmi_o | output | 1 | Non-maskable interrupt request |
| brk_o | output | 1 | Break level to the advanced timer |
| rdy_flag_o | output | N_SRC | Per-source ready flags |
| irq_o | output | 1 | Maskable ready interrupt request |

## Verification
The assertions check the following on every cycle:
- a detection always produces the forced selection and the enable clears on the next edge, and the PLL enable drops when the PLL path was in use;
- the pending bit holds until a clear, and a clear always wins;
- the watchdog counter stays in range and detection never fires on two cycles in a row;
- a ready flag clear always takes effect.

Only the bench's scenarios can show the rest:
- the detection latency after the monitored clock really stops;
- that a running clock is never reported;
- that the gating by selection and PLL source holds off detection;
- that the PLL enable survives a failure on the direct path;
- the routing of ready flags to the interrupt line.

// File: rtl/xfg_pkg.sv
package xfg_pkg;
  typedef enum logic [1:0] {
    SEL_INT = 2'd0,
    SEL_EXT = 2'd1,
    SEL_PLL = 2'd2
  } clk_sel_e;

  function automatic clk_sel_e decode_sel(input logic [1:0] raw);
    case (raw)
      2'd1:    return SEL_EXT;
      2'd2:    return SEL_PLL;
      default: return SEL_INT;
    endcase
  endfunction
endpackage

// File: rtl/xfg_edge_mon.sv
module xfg_edge_mon #(
  parameter int TIMEOUT     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  input  logic active_i,
  output logic det_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic                   tog_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          cnt_q;
  logic                   det_q;
  logic                   seen_edge;
  logic                   expire;

  // divide monitored clock so the reference domain sees level changes
  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tog_q};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign seen_edge = sync_q[SYNC_STAGES-1] ^ prev_q;
  assign expire    = active_i && !seen_edge && (cnt_q == LAST);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      det_q <= 1'b0;
    end else begin
      det_q <= expire;
      if (!active_i || seen_edge || expire) cnt_q <= '0;
      else                                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign det_o = det_q;

  AST_CNT_RANGE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
  AST_DET_SINGLE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    det_q |=> !det_q); // R4
endmodule

// File: rtl/xfg_rdy_flag.sv
module xfg_rdy_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   rise;

  assign rise = sync_q[SYNC_STAGES-1] && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (clr_i)     flag_q <= 1'b0;
      else if (rise) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q); // R9
endmodule

// File: rtl/xosc_fail_guard.sv
module xosc_fail_guard
  import xfg_pkg::*;
#(
  parameter int TIMEOUT     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int N_SRC       = 4
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             mon_clk_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_det_en_i,
  input  logic             cfg_xosc_en_i,
  input  logic             cfg_pll_en_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic             pll_src_ext_i,
  input  logic             fail_clr_i,
  input  logic [N_SRC-1:0] rdy_i,
  input  logic [N_SRC-1:0] rdy_ie_i,
  input  logic [N_SRC-1:0] rdy_clr_i,
  output logic [1:0]       sel_o,
  output logic             xosc_en_o,
  output logic             pll_en_o,
  output logic             det_en_o,
  output logic             nmi_o,
  output logic             brk_o,
  output logic [N_SRC-1:0] rdy_flag_o,
  output logic             irq_o
);
  clk_sel_e sel_q;
  logic     det_en_q, xosc_en_q, pll_en_q, pend_q;
  logic     active, det;

  assign active = det_en_q &&
                  ((sel_q == SEL_EXT) || ((sel_q == SEL_PLL) && pll_src_ext_i));

  xfg_edge_mon #(
    .TIMEOUT    (TIMEOUT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_mon (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .mon_clk_i(mon_clk_i),
    .active_i (active),
    .det_o    (det)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= SEL_INT;
      det_en_q  <= 1'b0;
      xosc_en_q <= 1'b0;
      pll_en_q  <= 1'b0;
    end else begin
      if (cfg_wr_i) begin
        sel_q     <= decode_sel(cfg_sel_i);
        det_en_q  <= cfg_det_en_i;
        xosc_en_q <= cfg_xosc_en_i;
        pll_en_q  <= cfg_pll_en_i;
      end
      // recovery overrides a coincident write
      if (det) begin
        sel_q     <= SEL_INT;
        det_en_q  <= 1'b0;
        xosc_en_q <= 1'b0;
        if (sel_q == SEL_PLL) pll_en_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (fail_clr_i) pend_q <= 1'b0;
    else if (det)        pend_q <= 1'b1;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_rdy
    xfg_rdy_flag #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
      .clk_i (ref_clk_i),
      .rst_ni(rst_ni),
      .rdy_i (rdy_i[g]),
      .clr_i (rdy_clr_i[g]),
      .flag_o(rdy_flag_o[g])
    );
  end

  assign irq_o     = |(rdy_flag_o & rdy_ie_i);
  assign sel_o     = sel_q;
  assign xosc_en_o = xosc_en_q;
  assign pll_en_o  = pll_en_q;
  assign det_en_o  = det_en_q;
  assign nmi_o     = pend_q;
  assign brk_o     = pend_q;

  AST_FORCE_SEL: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    det |=> sel_q == SEL_INT); // R5
  AST_SELF_OFF: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    det |=> !det_en_q && !xosc_en_q); // R5
  AST_PLL_OFF: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    det && (sel_q == SEL_PLL) |=> !pll_en_q); // R6
  AST_DET_GATED: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    det |-> $past(det_en_q)); // R3
  AST_PEND_SET: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    det && !fail_clr_i |=> pend_q); // R4
  AST_PEND_HOLD: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    pend_q && !fail_clr_i |=> pend_q); // R7
  AST_CLR_WINS: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail_clr_i |=> !pend_q); // R8
endmodule

// File: tb/xosc_fail_guard_bench.sv
module xosc_fail_guard_bench;
  localparam int TIMEOUT = 32;
  localparam int N_SRC   = 4;

  logic ref_clk = 1'b0, mon_clk = 1'b0, mon_run = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_det_en = 1'b0, cfg_xosc_en = 1'b0, cfg_pll_en = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic pll_src_ext = 1'b0, fail_clr = 1'b0;
  logic [N_SRC-1:0] rdy = '0, rdy_ie = '0, rdy_clr = '0;
  logic [1:0] sel;
  logic xosc_en, pll_en, det_en, nmi, brk, irq;
  logic [N_SRC-1:0] rdy_flag;

  int total = 0, bad = 0;

  always #5 ref_clk = ~ref_clk;          // 100 MHz
  always #3 if (mon_run) mon_clk = ~mon_clk;

  xosc_fail_guard #(.TIMEOUT(TIMEOUT), .N_SRC(N_SRC)) u_xosc_fail_guard (
    .ref_clk_i(ref_clk), .rst_ni(rst_n), .mon_clk_i(mon_clk),
    .cfg_wr_i(cfg_wr), .cfg_det_en_i(cfg_det_en), .cfg_xosc_en_i(cfg_xosc_en),
    .cfg_pll_en_i(cfg_pll_en), .cfg_sel_i(cfg_sel), .pll_src_ext_i(pll_src_ext),
    .fail_clr_i(fail_clr), .rdy_i(rdy), .rdy_ie_i(rdy_ie), .rdy_clr_i(rdy_clr),
    .sel_o(sel), .xosc_en_o(xosc_en), .pll_en_o(pll_en), .det_en_o(det_en),
    .nmi_o(nmi), .brk_o(brk), .rdy_flag_o(rdy_flag), .irq_o(irq)
  );

  typedef struct {
    string      req;
    int         id;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  function automatic logic [7:0] observe(int id);
    case (id)
      0: return {7'd0, nmi};
      1: return {7'd0, brk};
      2: return {6'd0, sel};
      3: return {7'd0, xosc_en};
      4: return {7'd0, pll_en};
      5: return {7'd0, det_en};
      6: return {7'd0, irq};
      default: return {4'd0, rdy_flag};
    endcase
  endfunction

  // monitor: pops expectations and compares away from the active edge
  always @(negedge ref_clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = observe(it.id);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sig%0d actual=%0h expected=%0h", it.req, it.id, act, it.exp);
      end
    end
  end

  task automatic expect_sig(string req, int id, logic [7:0] exp);
    item_t it;
    it.req = req; it.id = id; it.exp = exp;
    sb_q.push_back(it);
    @(negedge ref_clk);
    #1;
  endtask

  task automatic check_direct(string req, int act, int exp_lo, int exp_hi);
    total++;
    if (act < exp_lo || act > exp_hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic cfg_write(logic de, logic xe, logic pe, logic [1:0] s);
    @(posedge ref_clk); #1;
    cfg_det_en = de; cfg_xosc_en = xe; cfg_pll_en = pe; cfg_sel = s; cfg_wr = 1'b1;
    @(posedge ref_clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge ref_clk); #1;
    fail_clr = 1'b1;
    @(posedge ref_clk); #1;
    fail_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    expect_sig("R1 nmi", 0, 0);
    expect_sig("R1 brk", 1, 0);
    expect_sig("R1 sel", 2, 0);
    expect_sig("R1 xosc_en", 3, 0);
    expect_sig("R1 pll_en", 4, 0);
    expect_sig("R1 det_en", 5, 0);
    expect_sig("R1 irq", 6, 0);
    expect_sig("R1 flags", 7, 0);

    // R2 write, direct external path, R4 running clock never reported
    mon_run = 1'b1;
    cfg_write(1'b1, 1'b1, 1'b1, 2'd1);
    expect_sig("R2 sel", 2, 1);
    expect_sig("R2 det_en", 5, 1);
    expect_sig("R2 xosc_en", 3, 1);
    wait_cyc(200);
    expect_sig("R4 running no nmi", 0, 0);

    // R4 stop and measure latency
    @(posedge ref_clk); #1;
    mon_run = 1'b0;
    n = 0;
    while (!nmi && n < 200) begin
      @(negedge ref_clk);
      n++;
    end
    check_direct("R4 latency", n, TIMEOUT, TIMEOUT + 8);
    expect_sig("R7 brk level", 1, 1);
    expect_sig("R5 sel forced", 2, 0);
    expect_sig("R5 det_en cleared", 5, 0);
    expect_sig("R5 xosc_en cleared", 3, 0);
    expect_sig("R6 pll kept on direct path", 4, 1);
    wait_cyc(50);
    expect_sig("R7 nmi held", 0, 1);
    pulse_clr();
    expect_sig("R7 nmi cleared", 0, 0);
    expect_sig("R7 brk cleared", 1, 0);
    expect_sig("R7 sel not restored", 2, 0);

    // R6 PLL path fed by external oscillator
    mon_run = 1'b1;
    pll_src_ext = 1'b1;
    cfg_write(1'b1, 1'b1, 1'b1, 2'd2);
    wait_cyc(20);
    expect_sig("R2 sel pll", 2, 2);
    mon_run = 1'b0;
    wait_cyc(TIMEOUT + 12);
    expect_sig("R6 nmi", 0, 1);
    expect_sig("R6 pll_en cleared", 4, 0);
    expect_sig("R6 sel forced", 2, 0);
    pulse_clr();

    // R3 gating cases with the clock stopped
    pll_src_ext = 1'b0;
    cfg_write(1'b1, 1'b1, 1'b1, 2'd2);
    wait_cyc(100);
    expect_sig("R3 pll internal src no nmi", 0, 0);
    expect_sig("R3 sel kept", 2, 2);
    cfg_write(1'b0, 1'b1, 1'b0, 2'd1);
    wait_cyc(100);
    expect_sig("R3 disabled no nmi", 0, 0);
    expect_sig("R3 xosc_en kept", 3, 1);
    cfg_write(1'b1, 1'b1, 1'b0, 2'd0);
    wait_cyc(100);
    expect_sig("R3 internal sel no nmi", 0, 0);
    expect_sig("R3 det_en kept", 5, 1);
    cfg_write(1'b1, 1'b0, 1'b0, 2'd3);
    expect_sig("R2 code 3 stored as 0", 2, 0);

    // R8 clear held through detection
    @(posedge ref_clk); #1;
    fail_clr = 1'b1;
    cfg_write(1'b1, 1'b1, 1'b0, 2'd1);
    wait_cyc(TIMEOUT + 12);
    expect_sig("R8 pend stays low", 0, 0);
    expect_sig("R8 sel still forced", 2, 0);
    expect_sig("R8 det_en still cleared", 5, 0);
    fail_clr = 1'b0;

    // R9 ready flags
    rdy_ie = 4'b0001;
    rdy[0] = 1'b1;
    wait_cyc(5);
    expect_sig("R9 flag0", 7, 8'h01);
    expect_sig("R9 irq on", 6, 1);
    rdy[1] = 1'b1;
    wait_cyc(5);
    expect_sig("R9 flag1 masked", 7, 8'h03);
    @(posedge ref_clk); #1;
    rdy_clr = 4'b0001;
    @(posedge ref_clk); #1;
    rdy_clr = '0;
    expect_sig("R9 flag0 cleared", 7, 8'h02);
    expect_sig("R9 irq off", 6, 0);
    rdy_ie = 4'b0010;
    expect_sig("R9 irq via flag1", 6, 1);

    wait_cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule